// File: doc/BRIEF.md
# Codeword Output Buffer with Selectable Read Order

This block sits between an error-correction core and the consumer downstream of it. It holds one processed codeword in a 256-entry store of 9-bit words. Each word is a data byte plus one bit that marks the byte as corrected. The producer always delivers a codeword back to front: the last check byte of the incoming stream arrives first and the first message byte arrives last. The consumer reads through an active-low ready output and an active-low acknowledge strobe. A configuration input gives the codeword length N, and a mode bit picks one of two read orders.

Forward order returns the bytes in their original transmission order. This means the first byte the consumer sees is the last one the producer wrote, so readout has to wait until the whole codeword is stored. Reverse order returns the bytes in the order they were written. Readout can then start as soon as one byte is present and can follow the producer closely, but it never overtakes it. After the N-th acknowledged byte the buffer is empty again and accepts the next codeword.

Top module: `cw_out_buffer`

## Requirements
- R1: While `rstN` is low and after it is released, `rdyOutN` is high (not ready), and both the stored-byte count and the read position restart at zero.
- R2: Every stored entry returns its data byte on `dataOut` together with the corrected flag on `corrOut` (active high), exactly as written.
- R3: With `cfgReverse` = 0 (forward), the consumer receives the written bytes from last-written to first-written. The k-th byte read (k counted from 0) is the byte written in position N-1-k.
- R4: With `cfgReverse` = 0, `rdyOutN` stays high until all N bytes of the codeword are written.
- R5: With `cfgReverse` = 1, the consumer receives the bytes in the order they were written.
- R6: With `cfgReverse` = 1, `rdyOutN` goes low in the cycle after the first byte is written. It goes high whenever every byte written so far has been acknowledged, so the read position never passes the write position.
- R7: An `ackN` low while `rdyOutN` is high has no effect on the read position.
- R8: Once asserted for a complete codeword, `rdyOutN` stays low until the N-th acknowledge. After that acknowledge it goes high, and the next codeword is written from the start.
- R9: A write strobe that arrives after N bytes of the current codeword are stored is discarded. It changes neither the stored bytes nor the count.
- R10: In reverse mode, a write and an acknowledge in the same cycle both take effect: the read position advances and the new byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStrobe | input | 1 | Producer write strobe, one byte per asserted edge |
| wrByte | input | 8 | Byte written by the producer |
| wrCorr | input | 1 | Corrected flag for the written byte |
| cfgLen | input | 8 | Codeword length N (1 to 255), held stable while a codeword is buffered |
| cfgReverse | input | 1 | Read order: 1 = write order, 0 = original transmission order |
| ackN | input | 1 | Consumer acknowledge, active low, advances the read position |
| rdyOutN | output | 1 | Output ready, active low |
| dataOut | output | 8 | Byte at the current read position (undefined while not ready) |
| corrOut | output | 1 | Corrected flag of the byte on `dataOut` |

## Verification
In reverse mode a producer write and a consumer acknowledge can land on the same clock edge. Both must take effect: the count of stored bytes and the read position each move by one. The bench provokes this by driving a new byte and an acknowledge together while one unread byte is waiting. Afterwards it checks that ready is still asserted and that `dataOut` has moved on to the byte that was just written. It also drains a codeword exactly to the write position and checks that ready drops instead of running ahead.

// File: rtl/obuf_pkg.sv
package obuf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store the presented byte at the write index
    logic fwdSel;  // read addresses run from the block end downward
  } obufCtl_t;

endpackage

// File: rtl/obuf_ctrl.sv
module obuf_ctrl
  import obuf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrStrobe,
  input  logic [AW-1:0] cfgLen,
  input  logic          cfgReverse,
  input  logic          ackN,
  output logic          rdyOutN,
  output obufCtl_t      ctl,
  output logic [AW-1:0] wrIdx,
  output logic [AW-1:0] rdIdx
);

  logic [AW-1:0] wrCnt;
  logic [AW-1:0] rdCnt;
  logic          blockFull;
  logic          wrAccept;
  logic          avail;
  logic          rdAdv;
  logic          lastRd;

  assign blockFull = (wrCnt == cfgLen) && (wrCnt != '0);
  assign wrAccept  = wrStrobe && (wrCnt != cfgLen);
  assign avail     = cfgReverse ? (rdCnt != wrCnt) : blockFull;
  assign rdAdv     = !ackN && avail;
  assign lastRd    = rdAdv && (rdCnt == cfgLen - AW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt <= '0;
      rdCnt <= '0;
    end else if (lastRd) begin
      wrCnt <= '0;
      rdCnt <= '0;
    end else begin
      if (rdAdv)    rdCnt <= rdCnt + AW'(1);
      if (wrAccept) wrCnt <= wrCnt + AW'(1);
    end
  end

  assign rdyOutN    = !avail;
  assign ctl.wrEn   = wrAccept;
  assign ctl.fwdSel = !cfgReverse;
  assign wrIdx      = wrCnt;
  assign rdIdx      = rdCnt;

  // R6
  rd_behind_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt <= wrCnt);

  // R4
  fwd_full_before_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgReverse && !rdyOutN) |-> (wrCnt == cfgLen));

  // R7
  ack_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdyOutN && !ackN) |=> $stable(rdCnt));

  // R9
  overfill_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && (wrCnt == cfgLen) && ackN) |=> $stable(wrCnt));

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgReverse && !rdyOutN && ackN) |=> !rdyOutN);

  // R10
  both_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReverse && wrAccept && rdAdv && !lastRd)
      |=> (rdCnt == $past(rdCnt) + AW'(1)) && (wrCnt == $past(wrCnt) + AW'(1)));

endmodule

// File: rtl/obuf_datapath.sv
module obuf_datapath
  import obuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  obufCtl_t          ctl,
  input  logic [AW-1:0]     wrIdx,
  input  logic [AW-1:0]     rdIdx,
  input  logic [AW-1:0]     blkLen,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              wrCorr,
  output logic [DATA_W-1:0] dataOut,
  output logic              corrOut
);

  logic [WORD_W-1:0] store [DEPTH];
  logic [AW-1:0]     rdAddr;
  logic [WORD_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) store[wrIdx] <= {wrCorr, wrByte};
  end

  // forward order walks from the last stored entry back to the first
  assign rdAddr  = ctl.fwdSel ? (blkLen - rdIdx - AW'(1)) : rdIdx;
  assign rdWord  = store[rdAddr];
  assign dataOut = rdWord[DATA_W-1:0];
  assign corrOut = rdWord[DATA_W];

  // R3
  rd_addr_in_block_chk: assert property (@(posedge clk)
    (rdIdx < blkLen) |-> (rdAddr < blkLen));

endmodule

// File: rtl/cw_out_buffer.sv
module cw_out_buffer
  import obuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              wrCorr,
  input  logic [AW-1:0]     cfgLen,
  input  logic              cfgReverse,
  input  logic              ackN,
  output logic              rdyOutN,
  output logic [DATA_W-1:0] dataOut,
  output logic              corrOut
);

  obufCtl_t      ctl;
  logic [AW-1:0] wrIdx;
  logic [AW-1:0] rdIdx;

  obuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .cfgLen(cfgLen),
    .cfgReverse(cfgReverse), .ackN(ackN), .rdyOutN(rdyOutN),
    .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  obuf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx), .blkLen(cfgLen),
    .wrByte(wrByte), .wrCorr(wrCorr), .dataOut(dataOut), .corrOut(corrOut)
  );

endmodule

// File: tb/tb_cw_out_buffer.sv
module tb_cw_out_buffer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrByte = '0;
  logic       wrCorr = 1'b0;
  logic [7:0] cfgLen = 8'd3;
  logic       cfgReverse = 1'b0;
  logic       ackN = 1'b1;
  logic       rdyOutN;
  logic [7:0] dataOut;
  logic       corrOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  logic [7:0] expD [256];
  logic       expF [256];

  // {reverse, length, seed}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'd3,   8'h10},
    {1'b1, 8'd3,   8'h20},
    {1'b0, 8'd255, 8'h05},
    {1'b1, 8'd255, 8'hA0},
    {1'b0, 8'd1,   8'h77},
    {1'b1, 8'd17,  8'h3C}
  };

  cw_out_buffer dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrByte(wrByte),
    .wrCorr(wrCorr), .cfgLen(cfgLen), .cfgReverse(cfgReverse), .ackN(ackN),
    .rdyOutN(rdyOutN), .dataOut(dataOut), .corrOut(corrOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic f);
    @(negedge clk);
    wrStrobe = 1'b1; wrByte = d; wrCorr = f;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] d, input logic f);
    @(negedge clk);
    chk({req, " ready"}, int'(rdyOutN), 0);
    chk({req, " data"}, int'(dataOut), int'(d));
    chk({req, " flag"}, int'(corrOut), int'(f));
    ackN = 1'b0;
    @(negedge clk);
    ackN = 1'b1;
  endtask

  task automatic fill(input logic [7:0] seed, input int n);
    for (int i = 0; i < n; i++) begin
      expD[i] = seed + 8'(i * 13);
      expF[i] = ((i % 3) == 1);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 ready in reset", int'(rdyOutN), 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(rdyOutN), 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    doReset();

    // table-driven blocks: R2 R3 R4 R5 R8
    for (int v = 0; v < 6; v++) begin
      int n;
      n = int'(VEC[v][15:8]);
      cfgReverse = VEC[v][16];
      cfgLen = VEC[v][15:8];
      fill(VEC[v][7:0], n);
      for (int i = 0; i < n; i++) begin
        if (i == n - 1 && !cfgReverse)
          chk("R4 forward held off", int'(rdyOutN), 1);
        wr(expD[i], expF[i]);
      end
      for (int k = 0; k < n; k++) begin
        if (cfgReverse) rd("R5 R2 reverse order", expD[k], expF[k]);
        else            rd("R3 R2 forward order", expD[n-1-k], expF[n-1-k]);
      end
      chk("R8 ready released after block", int'(rdyOutN), 1);
    end

    // R6: reverse early start, and catching up with the writer
    cfgReverse = 1'b1; cfgLen = 8'd5;
    fill(8'h51, 5);
    wr(expD[0], expF[0]);
    chk("R6 ready after first write", int'(rdyOutN), 0);
    rd("R6 first byte", expD[0], expF[0]);
    chk("R6 ready drops when caught up", int'(rdyOutN), 1);
    for (int i = 1; i < 5; i++) wr(expD[i], expF[i]);
    for (int k = 1; k < 5; k++) rd("R6 rest", expD[k], expF[k]);

    // R10: simultaneous write and acknowledge
    cfgLen = 8'd4;
    fill(8'hC3, 4);
    wr(expD[0], expF[0]);
    @(negedge clk);
    chk("R10 byte0 shown", int'(dataOut), int'(expD[0]));
    wrStrobe = 1'b1; wrByte = expD[1]; wrCorr = expF[1]; ackN = 1'b0;
    @(negedge clk);
    wrStrobe = 1'b0; ackN = 1'b1;
    chk("R10 still ready", int'(rdyOutN), 0);
    chk("R10 next byte shown", int'(dataOut), int'(expD[1]));
    wr(expD[2], expF[2]);
    wr(expD[3], expF[3]);
    for (int k = 1; k < 4; k++) rd("R10 drain", expD[k], expF[k]);
    chk("R10 empty", int'(rdyOutN), 1);

    // R7: acknowledges while not ready are ignored
    cfgReverse = 1'b0; cfgLen = 8'd3;
    fill(8'h09, 3);
    @(negedge clk); ackN = 1'b0;
    @(negedge clk); @(negedge clk); ackN = 1'b1;
    wr(expD[0], expF[0]);
    wr(expD[1], expF[1]);
    @(negedge clk); ackN = 1'b0;
    @(negedge clk); ackN = 1'b1;
    wr(expD[2], expF[2]);
    for (int k = 0; k < 3; k++) rd("R7 order intact", expD[2-k], expF[2-k]);

    // R9: overfill discarded; R8: next block starts fresh
    fill(8'h40, 3);
    for (int i = 0; i < 3; i++) wr(expD[i], expF[i]);
    wr(8'hEE, 1'b1);
    for (int k = 0; k < 3; k++) rd("R9 overfill dropped", expD[2-k], expF[2-k]);
    chk("R9 nothing extra", int'(rdyOutN), 1);
    fill(8'h90, 3);
    for (int i = 0; i < 3; i++) wr(expD[i], expF[i]);
    for (int k = 0; k < 3; k++) rd("R8 next block", expD[2-k], expF[2-k]);

    // R1: reset mid-block clears state
    cfgReverse = 1'b1;
    wr(8'h11, 1'b0);
    wr(8'h22, 1'b0);
    doReset();
    fill(8'h61, 3);
    for (int i = 0; i < 3; i++) wr(expD[i], expF[i]);
    for (int k = 0; k < 3; k++) rd("R1 restart from zero", expD[k], expF[k]);

    finishRun();
  end
endmodule